// File: doc/BRIEF.md
# Single-Precision Compare and Sign Unit

This block handles the non-arithmetic single-precision floating-point operations of a scalar FP pipeline. Given two 32-bit IEEE-754 operands (`src_a` playing the first source register, `src_b` the second) and an operation code, it either orders the two operands or applies a sign operation to `src_b`. A compare builds a 2-bit condition code and merges it into a copy of the status word on `stat_in`. It also raises an invalid-operation flag when the ordering is unordered and the compare rules call for it. A sign operation returns a 32-bit result and leaves the status word as it was.

The block is sequenced by a two-state machine. `ST_IDLE` is the reset state and means "no response this cycle". `ST_RESP` means "a registered response is on the outputs". The transition `IDLE->RESP` and the self-loop `RESP->RESP` are taken on a cycle with `in_valid` high. The transition `RESP->IDLE` and the self-loop `IDLE->IDLE` are taken on a cycle with `in_valid` low. Every accepted request is answered exactly one cycle later, so requests can be issued back to back.

Operation codes on `op_sel` are 0 copy, 1 absolute value, 2 negate, 4 quiet compare and 5 signaling compare. Codes 3, 6 and 7 are unused.

Top module: `fpcs_unit`

## Requirements
- R1: After reset, `done_out`, `invalid_out`, `res_out` and `stat_out` are all zero.
- R2: `done_out` is high in exactly the cycles that follow a cycle with `in_valid` high, and all outputs carry that request's response in that cycle.
- R3: A compare (op 4 or 5) writes its condition code into `stat_out[11:10]`, and every other bit of `stat_out` equals the corresponding bit of `stat_in`.
- R4: For two non-NaN operands the condition code is 0 when they are equal, 1 when `src_a` < `src_b` and 2 when `src_a` > `src_b`. Infinities and denormals are ordered by their numeric values.
- R5: +0 and -0 compare equal (code 0) in either order.
- R6: If either operand is a NaN (exponent all ones, fraction nonzero), the code is 3. With op 5 (signaling compare), `invalid_out` is raised.
- R7: With op 4 (quiet compare), `invalid_out` is raised only when the result is unordered and at least one operand is a signaling NaN, meaning fraction bit 22 is 0. Quiet NaNs alone do not raise it.
- R8: Op 0 returns `src_b` unchanged, op 1 returns `src_b` with bit 31 cleared, and op 2 returns `src_b` with bit 31 inverted. None of the three raises `invalid_out`, and each passes `stat_in` to `stat_out` unchanged.
- R9: Unused op codes (3, 6, 7) return a zero result, pass `stat_in` unchanged and never raise `invalid_out`.
- R10: Compares return a zero result on `res_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe, one request per high cycle |
| op_sel | input | 3 | Operation code (0 copy, 1 abs, 2 negate, 4 quiet compare, 5 signaling compare) |
| src_a | input | 32 | First operand (compare only) |
| src_b | input | 32 | Second operand |
| stat_in | input | 32 | Status word to be updated |
| res_out | output | 32 | Result of copy, absolute value or negate |
| stat_out | output | 32 | Status word with the condition code merged in |
| invalid_out | output | 1 | Invalid-operation flag, valid with `done_out` |
| done_out | output | 1 | Response valid |

## Verification
A wrong sequencer state shows up as `done_out` being missing, doubled or stuck in the cycle after a request. This is seen on the very next clock edge, and back-to-back requests expose a failure to remain in `ST_RESP`. A wrong operand classification or a wrong ordering decision shows up as a bad condition code in `stat_out[11:10]`, or as a wrong `invalid_out`, in the response cycle of the affected operand pair. For that reason the operand sweep pairs every class with every other class: zeros, denormals, normals, infinities, quiet NaNs and signaling NaNs. A corrupted merge shows up as a changed bit outside the code field, and this is caught by varying the status word on every request.

// File: rtl/fpcs_pkg.sv
package fpcs_pkg;

    // operation codes on op_sel
    localparam logic [2:0] OP_MOVE = 3'd0;
    localparam logic [2:0] OP_ABS  = 3'd1;
    localparam logic [2:0] OP_NEG  = 3'd2;
    localparam logic [2:0] OP_CMPQ = 3'd4;
    localparam logic [2:0] OP_CMPS = 3'd5;

    // condition code values
    localparam logic [1:0] CC_EQ = 2'd0;
    localparam logic [1:0] CC_LT = 2'd1;
    localparam logic [1:0] CC_GT = 2'd2;
    localparam logic [1:0] CC_UN = 2'd3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } fpcs_state_e;

    typedef struct packed {
        logic nan;
        logic snan;
        logic zero;
    } fpcs_class_t;

endpackage

// File: rtl/fpcs_classify.sv
module fpcs_classify
    import fpcs_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] val,
    output fpcs_class_t           cls
);
    localparam int MAG_W = EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_max;

    assign exp_f   = val[MAG_W-1:FRAC_W];
    assign frac_f  = val[FRAC_W-1:0];
    assign exp_max = &exp_f;

    always_comb begin
        cls.nan  = exp_max && (|frac_f);
        cls.snan = exp_max && (|frac_f) && !frac_f[FRAC_W-1];
        cls.zero = ~|val[MAG_W-1:0];
    end

endmodule

// File: rtl/fpcs_order.sv
module fpcs_order
    import fpcs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              nan_a,
    input  logic              nan_b,
    input  logic              zero_a,
    input  logic              zero_b,
    output logic [1:0]        cc,
    output logic              unord
);
    localparam int SIGN = DATA_W - 1;

    logic mag_lt;
    logic mag_eq;

    always_comb begin
        mag_lt = a[SIGN-1:0] < b[SIGN-1:0];
        mag_eq = a[SIGN-1:0] == b[SIGN-1:0];
        unord  = nan_a | nan_b;
        if (unord)
            cc = CC_UN;
        else if (zero_a && zero_b)
            cc = CC_EQ;
        else if (a[SIGN] != b[SIGN])
            cc = a[SIGN] ? CC_LT : CC_GT;
        else if (mag_eq)
            cc = CC_EQ;
        else if (a[SIGN])
            cc = mag_lt ? CC_GT : CC_LT;
        else
            cc = mag_lt ? CC_LT : CC_GT;
    end

endmodule

// File: rtl/fpcs_sign.sv
module fpcs_sign
    import fpcs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res
);
    localparam int SIGN = DATA_W - 1;

    always_comb begin
        res = '0;
        case (op)
            OP_MOVE: res = b;
            OP_ABS:  res = {1'b0, b[SIGN-1:0]};
            OP_NEG:  res = {~b[SIGN], b[SIGN-1:0]};
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/fpcs_unit.sv
module fpcs_unit
    import fpcs_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int STAT_W = 32,
    parameter int CC_LSB = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [2:0]               op_sel,
    input  logic [EXP_W+FRAC_W:0]    src_a,
    input  logic [EXP_W+FRAC_W:0]    src_b,
    input  logic [STAT_W-1:0]        stat_in,
    output logic [EXP_W+FRAC_W:0]    res_out,
    output logic [STAT_W-1:0]        stat_out,
    output logic                     invalid_out,
    output logic                     done_out
);
    localparam int DATA_W = 1 + EXP_W + FRAC_W;
    localparam int N_OPND = 2;

    fpcs_state_e state_q, state_d;

    logic [DATA_W-1:0] opnd [N_OPND];
    fpcs_class_t       cls  [N_OPND];

    logic [1:0]        cc_w;
    logic              unord_w;
    logic [DATA_W-1:0] sign_res_w;
    logic              is_cmp;
    logic              inv_w;
    logic [STAT_W-1:0] stat_w;

    logic [DATA_W-1:0] res_q;
    logic [STAT_W-1:0] stat_q;
    logic              inv_q;

    assign opnd[0] = src_a;
    assign opnd[1] = src_b;

    // one classifier per source operand
    generate
        for (genvar g = 0; g < N_OPND; g++) begin : g_cls
            fpcs_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
                .val (opnd[g]),
                .cls (cls[g])
            );
        end
    endgenerate

    fpcs_order #(.DATA_W(DATA_W)) u_order (
        .a      (src_a),
        .b      (src_b),
        .nan_a  (cls[0].nan),
        .nan_b  (cls[1].nan),
        .zero_a (cls[0].zero),
        .zero_b (cls[1].zero),
        .cc     (cc_w),
        .unord  (unord_w)
    );

    fpcs_sign #(.DATA_W(DATA_W)) u_sign (
        .op  (op_sel),
        .b   (src_b),
        .res (sign_res_w)
    );

    always_comb begin
        is_cmp = (op_sel == OP_CMPQ) || (op_sel == OP_CMPS);
        inv_w  = is_cmp && unord_w &&
                 ((op_sel == OP_CMPS) || cls[0].snan || cls[1].snan);
        stat_w = stat_in;
        if (is_cmp)
            stat_w[CC_LSB +: 2] = cc_w;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = in_valid ? ST_RESP : ST_IDLE;
        endcase
    end

    // response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q  <= '0;
            stat_q <= '0;
            inv_q  <= 1'b0;
        end else if (in_valid) begin
            res_q  <= sign_res_w;
            stat_q <= stat_w;
            inv_q  <= inv_w;
        end else begin
            inv_q  <= 1'b0;
        end
    end

    assign res_out     = res_q;
    assign stat_out    = stat_q;
    assign invalid_out = inv_q;
    assign done_out    = (state_q == ST_RESP);

    // ---------------- assertions ----------------
    p_done_after_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done_out);

    p_no_done_without_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done_out);

    p_cmp_keeps_other_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_cmp) |=>
            ((stat_out ^ $past(stat_in)) & ~({{(STAT_W-2){1'b0}}, 2'b11} << CC_LSB)) == '0);

    p_invalid_only_unordered_r6: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_out |-> (done_out && stat_out[CC_LSB +: 2] == CC_UN));

    p_sign_ops_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_cmp) |=> (!invalid_out && stat_out == $past(stat_in)));

    p_cmp_zero_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_cmp) |=> res_out == '0);

endmodule

// File: tb/test_fpcs_unit.sv
`timescale 1ns/1ps
module test_fpcs_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] stat_in = '0;
    logic [31:0] res_out;
    logic [31:0] stat_out;
    logic        invalid_out;
    logic        done_out;

    int total = 0;
    int bad = 0;
    int seq = 0;

    always #2.5 clk = ~clk;

    fpcs_unit i_fpcs_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .op_sel      (op_sel),
        .src_a       (src_a),
        .src_b       (src_b),
        .stat_in     (stat_in),
        .res_out     (res_out),
        .stat_out    (stat_out),
        .invalid_out (invalid_out),
        .done_out    (done_out)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] sample_val(input int i);
        case (i)
            0:  return 32'h0000_0000;
            1:  return 32'h8000_0000;
            2:  return 32'h0000_0001;
            3:  return 32'h8000_0001;
            4:  return 32'h007F_FFFF;
            5:  return 32'h807F_FFFF;
            6:  return 32'h0080_0000;
            7:  return 32'h3F80_0000;
            8:  return 32'hBF80_0000;
            9:  return 32'h3F80_0001;
            10: return 32'h4000_0000;
            11: return 32'hC000_0000;
            12: return 32'h7F7F_FFFF;
            13: return 32'hFF7F_FFFF;
            14: return 32'h7F80_0000;
            15: return 32'hFF80_0000;
            16: return 32'h7FC0_0000;
            17: return 32'hFFC0_0000;
            18: return 32'h7F80_0001;
            19: return 32'hFF80_0001;
            20: return 32'h7FBF_FFFF;
            21: return 32'h7FFF_FFFF;
            22: return 32'h4049_0FDB;
            default: return 32'hC049_0FDB;
        endcase
    endfunction

    function automatic bit is_nan(input logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction

    function automatic bit is_snan(input logic [31:0] v);
        return is_nan(v) && (v[22] == 1'b0);
    endfunction

    // numeric ordering key: signed magnitude mapped onto an integer line
    function automatic longint okey(input logic [31:0] v);
        longint m;
        m = longint'(v[30:0]);
        return v[31] ? -m : m;
    endfunction

    function automatic logic [31:0] next_stat();
        seq++;
        return 32'hA5C3_0F00 ^ (32'(seq) * 32'h9E37_79B9);
    endfunction

    // one request, response sampled one cycle later at the falling edge
    task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] st);
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; src_a = a; src_b = b; stat_in = st;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_cmp(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] st, exp_st;
        logic [1:0]  ecc;
        bit          einv;
        string       tag;
        st = next_stat();
        if (is_nan(a) || is_nan(b)) begin
            ecc  = 2'd3;
            einv = (op == 3'd5) || is_snan(a) || is_snan(b);
            tag  = (op == 3'd5) ? "R6" : "R7";
        end else begin
            if (okey(a) == okey(b)) ecc = 2'd0;
            else if (okey(a) < okey(b)) ecc = 2'd1;
            else ecc = 2'd2;
            einv = 1'b0;
            tag  = (a[30:0] == 0 && b[30:0] == 0) ? "R5" : "R4";
        end
        exp_st = st;
        exp_st[11:10] = ecc;
        issue(op, a, b, st);
        check({tag, " cc"}, {30'd0, stat_out[11:10]}, {30'd0, ecc});
        check({tag, " invalid"}, {31'd0, invalid_out}, {31'd0, einv});
        check("R3 status merge", stat_out, exp_st);
        check("R10 cmp result", res_out, 32'd0);
        check("R2 done", {31'd0, done_out}, 32'd1);
    endtask

    task automatic check_sign(input logic [2:0] op, input logic [31:0] b);
        logic [31:0] st, er;
        string tag;
        st = next_stat();
        case (op)
            3'd0: begin er = b; tag = "R8 move"; end
            3'd1: begin er = b & 32'h7FFF_FFFF; tag = "R8 abs"; end
            3'd2: begin er = b ^ 32'h8000_0000; tag = "R8 neg"; end
            default: begin er = 32'd0; tag = "R9 unused"; end
        endcase
        issue(op, 32'h7F80_0001, b, st);
        check({tag, " result"}, res_out, er);
        check({tag, " status"}, stat_out, st);
        check({tag, " invalid"}, {31'd0, invalid_out}, 32'd0);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] st1, st2;
        #12;
        check("R1 done", {31'd0, done_out}, 32'd0);
        check("R1 invalid", {31'd0, invalid_out}, 32'd0);
        check("R1 result", res_out, 32'd0);
        check("R1 status", stat_out, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle done", {31'd0, done_out}, 32'd0);

        // every operand class against every other, both compare flavours
        for (int i = 0; i < 24; i++)
            for (int j = 0; j < 24; j++) begin
                check_cmp(3'd4, sample_val(i), sample_val(j));
                check_cmp(3'd5, sample_val(i), sample_val(j));
            end

        // sign operations and unused codes
        for (int i = 0; i < 24; i++)
            for (int o = 0; o < 8; o++)
                if (o != 4 && o != 5)
                    check_sign(3'(o), sample_val(i));

        // done drops after a gap
        @(negedge clk);
        check("R2 done low after gap", {31'd0, done_out}, 32'd0);
        check("R2 invalid low after gap", {31'd0, invalid_out}, 32'd0);

        // back-to-back requests
        st1 = next_stat();
        st2 = next_stat();
        @(negedge clk);
        in_valid = 1'b1; op_sel = 3'd5; src_a = 32'h7FC0_0000; src_b = 32'h3F80_0000; stat_in = st1;
        @(negedge clk);
        check("R2 b2b first done", {31'd0, done_out}, 32'd1);
        check("R6 b2b first invalid", {31'd0, invalid_out}, 32'd1);
        check("R3 b2b first status", stat_out, st1 | 32'h0000_0C00);
        op_sel = 3'd2; src_b = 32'h3F80_0000; stat_in = st2;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 b2b second done", {31'd0, done_out}, 32'd1);
        check("R8 b2b second result", res_out, 32'hBF80_0000);
        check("R8 b2b second invalid", {31'd0, invalid_out}, 32'd0);
        check("R8 b2b second status", stat_out, st2);
        @(negedge clk);
        check("R2 b2b done drops", {31'd0, done_out}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule